// File: doc/BRIEF.md
# Battery-Backed SRAM Chip-Enable Gate

This block stands between a host's active-low chip enable and a static RAM whose contents are kept alive by a battery. External comparators supply digital flags: the supply has dropped below its 5% trip level, it has dropped below its 10% trip level, and it has dropped below the battery level. Other flags report whether each of two batteries is low, whether the second battery is fitted, and whether it is the higher of the two. A tolerance strap selects which trip flag counts as a power failure. The block derives the gated chip enable, a backup-enable output and a seal indication from these flags.

While the supply is good, the host chip enable reaches the RAM through gates only. When the supply fails, the RAM is write protected. A memory cycle already under way is allowed to finish before protection starts. When the supply comes back, the RAM stays locked for a recovery interval. The battery in use is then checked once. If it is low, the second memory cycle after power-up is refused, so software that writes and then reads back a location can detect the weak battery.

When batteries are first attached, which is modelled by reset, the block sits in a seal state that keeps the RAM rail and the chip enable low. Battery backup can only start after the supply has been good once.

Top module: `bbsram_ce_gate`

## Requirements
- R1: In the normal state the output `ce_n_out` equals `ce_n_in` in the same cycle through combinational gates only. The exception is a blocked cycle (R4).
- R2: If a power fail is detected while `ce_n_in` is low (active), `ce_n_out` keeps following `ce_n_in` until the input goes high. From then on `ce_n_out` stays high.
- R3: With `tol_sel` = 0, `sup_below_5` defines power fail. With `tol_sel` = 1, `sup_below_10` defines it and `sup_below_5` is ignored.
- R4: If the power-up battery check found a low battery, the second assertion of `ce_n_in` after recovery is blocked (`ce_n_out` = 1). The first assertion and the third and later assertions pass. A cycle is counted when `ce_n_in` rises.
- R5: The battery in use is battery 2 when `bat2_present` = 1 and `bat2_higher` = 1; otherwise it is battery 1. Only the low flag of the battery in use counts. When `bat2_present` = 0, `bat2_low` never causes a warning.
- R6: After reset the block is in seal: `seal_active` = 1, `ce_n_out` = 0 and `backup_en` = 0 whatever the other inputs are. Seal ends the first time the supply is seen to be good.
- R7: After the supply becomes good, `ce_n_out` stays high for `REC_CYCLES` clock cycles before pass-through resumes.
- R8: `bat_low_stat` is loaded from the in-use battery flag when recovery starts. It holds its value until the next power-up, when it is loaded again.
- R9: `backup_en` is 1 exactly when seal has ended and `sup_below_bat` (synchronized) is 1.
- R10: If a power fail is detected while `ce_n_in` is high, `ce_n_out` is forced high. It stays high until the supply returns and recovery completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; models first battery attach |
| ce_n_in | input | 1 | Host chip enable, active low |
| tol_sel | input | 1 | Trip select: 0 = 5% flag, 1 = 10% flag |
| sup_below_5 | input | 1 | Supply below 5% trip level |
| sup_below_10 | input | 1 | Supply below 10% trip level |
| sup_below_bat | input | 1 | Supply below battery voltage |
| bat1_low | input | 1 | Battery 1 below 2.0 V |
| bat2_low | input | 1 | Battery 2 below 2.0 V |
| bat2_present | input | 1 | Battery 2 fitted |
| bat2_higher | input | 1 | Battery 2 voltage exceeds battery 1 |
| ce_n_out | output | 1 | Gated chip enable to the RAM, active low |
| backup_en | output | 1 | Battery backup of the RAM rail enabled |
| seal_active | output | 1 | Seal state indication |
| bat_low_stat | output | 1 | Latched result of the power-up battery check |

## Verification
The bench applies a power fail in two ways: once while the chip enable is idle and once in the middle of an active cycle. Comparing the two shows whether protection is immediate in the first case and deferred in the second. Power-ups are run with a good battery, with a low battery 1 alone, with a low battery 1 beside a good, higher battery 2, and with a low flag on an absent battery 2. Three cycles follow each power-up, which shows whether exactly the second cycle is refused and only when the in-use battery is low. The tolerance strap is flipped while `sup_below_5` stays set, to show which trip flag governs. The run starts from seal, which shows the driven-low outputs and the release of backup.

// File: rtl/bbsram_pkg.sv
package bbsram_pkg;

    typedef enum logic [2:0] {
        ST_SEAL = 3'd0,
        ST_REC  = 3'd1,
        ST_ACT  = 3'd2,
        ST_HOLD = 3'd3,
        ST_FAIL = 3'd4
    } gate_st_e;

    // all asynchronous inputs, synchronized as one word
    typedef struct packed {
        logic ce_n;
        logic tol;
        logic below5;
        logic below10;
        logic below_bat;
        logic bat1_low;
        logic bat2_low;
        logic bat2_present;
        logic bat2_higher;
    } flags_t;

    localparam int unsigned FLAGS_W = $bits(flags_t);

    // safe view before the first sample: supply absent, host idle
    localparam flags_t FLAGS_RST = '{
        ce_n: 1'b1, tol: 1'b0, below5: 1'b1, below10: 1'b1,
        below_bat: 1'b1, bat1_low: 1'b0, bat2_low: 1'b0,
        bat2_present: 1'b0, bat2_higher: 1'b0
    };

    localparam int unsigned CYC_W       = 2;
    localparam int unsigned CYC_BLOCKED = 1;  // completed cycles before the refused one
    localparam int unsigned CYC_SAT     = 2;

    function automatic logic pick_fail(input flags_t f);
        return f.tol ? f.below10 : f.below5;
    endfunction

    function automatic logic pick_bat_low(input flags_t f);
        if (f.bat2_present && f.bat2_higher)
            return f.bat2_low;
        return f.bat1_low;
    endfunction

endpackage

// File: rtl/bbsram_sync.sv
module bbsram_sync #(
    parameter int unsigned          W       = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [W-1:0]         RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bbsram_bat_check.sv
module bbsram_bat_check
    import bbsram_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t flags,
    output logic   bat_low_q
);
    logic in_use_low;

    assign in_use_low = pick_bat_low(flags);

    always_ff @(posedge clk) begin
        if (rst)       bat_low_q <= 1'b0;
        else if (load) bat_low_q <= in_use_low;
    end

    // R8
    batlow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(bat_low_q));
endmodule

// File: rtl/bbsram_cycle_ctr.sv
module bbsram_cycle_ctr
    import bbsram_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic ce_n_s,
    input  logic bat_low,
    output logic blk
);
    logic             ce_prev;
    logic [CYC_W-1:0] cnt;
    logic             ce_rise;

    assign ce_rise = ce_n_s && !ce_prev;

    always_ff @(posedge clk) begin
        if (rst) ce_prev <= 1'b1;
        else     ce_prev <= ce_n_s;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && ce_rise && cnt != CYC_W'(CYC_SAT))
            cnt <= cnt + 1'b1;
    end

    assign blk = bat_low && (cnt == CYC_W'(CYC_BLOCKED));

    // R4
    cyc_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CYC_W'(CYC_SAT) && !clr) |=> cnt == CYC_W'(CYC_SAT));
endmodule

// File: rtl/bbsram_rec_timer.sv
module bbsram_rec_timer #(
    parameter int unsigned REC_CYCLES = 8_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int unsigned RW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;

    logic [RW-1:0] cnt;

    assign done = run && (cnt == RW'(REC_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    // R7
    rec_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
endmodule

// File: rtl/bbsram_ce_gate.sv
module bbsram_ce_gate
    import bbsram_pkg::*;
#(
    parameter int unsigned REC_CYCLES  = 8_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n_in,
    input  logic tol_sel,
    input  logic sup_below_5,
    input  logic sup_below_10,
    input  logic sup_below_bat,
    input  logic bat1_low,
    input  logic bat2_low,
    input  logic bat2_present,
    input  logic bat2_higher,
    output logic ce_n_out,
    output logic backup_en,
    output logic seal_active,
    output logic bat_low_stat
);
    flags_t   raw_f, s_f;
    gate_st_e st, nxt;
    logic     fail, rec_done, enter_rec, blk, backup_q;

    assign raw_f = '{
        ce_n: ce_n_in, tol: tol_sel, below5: sup_below_5,
        below10: sup_below_10, below_bat: sup_below_bat,
        bat1_low: bat1_low, bat2_low: bat2_low,
        bat2_present: bat2_present, bat2_higher: bat2_higher
    };

    bbsram_sync #(
        .W       (FLAGS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (FLAGS_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_f),
        .q   (s_f)
    );

    assign fail = pick_fail(s_f);

    bbsram_rec_timer #(.REC_CYCLES(REC_CYCLES)) u_rec (
        .clk  (clk),
        .rst  (rst),
        .run  (st == ST_REC),
        .done (rec_done)
    );

    always_comb begin
        nxt = st;
        unique case (st)
            ST_SEAL: if (!fail) nxt = ST_REC;
            ST_REC:  if (fail) nxt = ST_FAIL;
                     else if (rec_done) nxt = ST_ACT;
            ST_ACT:  if (fail) nxt = s_f.ce_n ? ST_FAIL : ST_HOLD;
            ST_HOLD: if (s_f.ce_n) nxt = ST_FAIL;
            ST_FAIL: if (!fail) nxt = ST_REC;
            default: nxt = ST_SEAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_SEAL;
        else     st <= nxt;
    end

    assign enter_rec = (nxt == ST_REC) && (st != ST_REC);

    bbsram_bat_check u_bat (
        .clk       (clk),
        .rst       (rst),
        .load      (enter_rec),
        .flags     (s_f),
        .bat_low_q (bat_low_stat)
    );

    bbsram_cycle_ctr u_cyc (
        .clk     (clk),
        .rst     (rst),
        .clr     (enter_rec),
        .en      (st == ST_ACT),
        .ce_n_s  (s_f.ce_n),
        .bat_low (bat_low_stat),
        .blk     (blk)
    );

    always_ff @(posedge clk) begin
        if (rst) backup_q <= 1'b0;
        else     backup_q <= (st != ST_SEAL) && (nxt != ST_SEAL) && s_f.below_bat;
    end

    always_comb begin
        unique case (st)
            ST_SEAL:         ce_n_out = 1'b0;
            ST_ACT, ST_HOLD: ce_n_out = ce_n_in | blk;
            default:         ce_n_out = 1'b1;
        endcase
    end

    assign backup_en   = backup_q;
    assign seal_active = (st == ST_SEAL);

    // R6
    seal_out_chk: assert property (@(posedge clk) disable iff (rst)
        seal_active |-> (!ce_n_out && !backup_en));
    // R7
    recov_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REC) |-> ce_n_out);
    // R10
    fail_prot_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FAIL) |-> ce_n_out);
    // R2
    hold_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !ce_n_in && !blk) |-> !ce_n_out);
    // R9
    backup_seal_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(backup_en) |-> !seal_active);
endmodule

// File: tb/bbsram_ce_gate_tb_top.sv
module bbsram_ce_gate_tb_top;
    localparam int unsigned REC = 20;

    logic clk = 1'b0;
    logic rst;
    logic ce_n_in, tol_sel, sup_below_5, sup_below_10, sup_below_bat;
    logic bat1_low, bat2_low, bat2_present, bat2_higher;
    logic ce_n_out, backup_en, seal_active, bat_low_stat;

    always #5 clk = ~clk;

    bbsram_ce_gate #(.REC_CYCLES(REC)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ce_n_in      (ce_n_in),
        .tol_sel      (tol_sel),
        .sup_below_5  (sup_below_5),
        .sup_below_10 (sup_below_10),
        .sup_below_bat(sup_below_bat),
        .bat1_low     (bat1_low),
        .bat2_low     (bat2_low),
        .bat2_present (bat2_present),
        .bat2_higher  (bat2_higher),
        .ce_n_out     (ce_n_out),
        .backup_en    (backup_en),
        .seal_active  (seal_active),
        .bat_low_stat (bat_low_stat)
    );

    typedef struct {
        string req;
        int    sig;   // 0 ce_n_out, 1 backup_en, 2 seal_active, 3 bat_low_stat
        logic  exp;
    } item_t;

    item_t q[$];
    event  smp;
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic  act;
                it = q.pop_front();
                case (it.sig)
                    0:       act = ce_n_out;
                    1:       act = backup_en;
                    2:       act = seal_active;
                    default: act = bat_low_stat;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sig=%0d actual=%b expected=%b t=%0t",
                             it.req, it.sig, act, it.exp, $time);
                end
            end
        end
    end

    task automatic chk(input string req, input int sig, input logic exp);
        #1;
        q.push_back('{req, sig, exp});
        -> smp;
        #1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mem_cycle(input string req, input logic exp);
        ce_n_in = 1'b0;
        chk(req, 0, exp);
        cyc(3);
        ce_n_in = 1'b1;
        cyc(6);
    endtask

    task automatic power_up();
        sup_below_5 = 1'b0; sup_below_10 = 1'b0; sup_below_bat = 1'b0;
        cyc(REC + 12);
    endtask

    task automatic power_down();
        sup_below_5 = 1'b1; sup_below_10 = 1'b1; sup_below_bat = 1'b1;
        cyc(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ce_n_in = 1'b1; tol_sel = 1'b0;
        sup_below_5 = 1'b1; sup_below_10 = 1'b1; sup_below_bat = 1'b1;
        bat1_low = 1'b0; bat2_low = 1'b0; bat2_present = 1'b0; bat2_higher = 1'b0;
        cyc(4);
        rst = 1'b0;
        cyc(1);
        // R6 reset state: seal, outputs driven low
        chk("R6", 2, 1'b1);
        chk("R6", 0, 1'b0);
        chk("R6", 1, 1'b0);
        cyc(8);
        chk("R6", 1, 1'b0);   // supply below battery yet no backup in seal

        // first power-up leaves seal, recovery lock
        sup_below_5 = 1'b0; sup_below_10 = 1'b0; sup_below_bat = 1'b0;
        cyc(8);
        chk("R6", 2, 1'b0);
        ce_n_in = 1'b0;
        chk("R7", 0, 1'b1);
        ce_n_in = 1'b1;
        cyc(REC + 6);
        ce_n_in = 1'b0;
        chk("R1", 0, 1'b0);
        ce_n_in = 1'b1;
        chk("R1", 0, 1'b1);
        chk("R8", 3, 1'b0);

        // good battery: every cycle passes
        mem_cycle("R4", 1'b0);
        mem_cycle("R4", 1'b0);
        mem_cycle("R4", 1'b0);

        // R10 fail while idle, R9 backup once seal is over
        sup_below_5 = 1'b1; sup_below_bat = 1'b1;
        cyc(6);
        ce_n_in = 1'b0;
        chk("R10", 0, 1'b1);
        chk("R9", 1, 1'b1);
        ce_n_in = 1'b1;
        cyc(2);

        // R3 tolerance strap: 10% flag governs, 5% flag ignored
        tol_sel = 1'b1; sup_below_10 = 1'b0; sup_below_bat = 1'b0;
        cyc(REC + 12);
        ce_n_in = 1'b0;
        chk("R3", 0, 1'b0);
        ce_n_in = 1'b1;
        chk("R9", 1, 1'b0);
        cyc(4);
        sup_below_10 = 1'b1;
        cyc(6);
        ce_n_in = 1'b0;
        chk("R3", 0, 1'b1);
        ce_n_in = 1'b1;
        tol_sel = 1'b0;
        cyc(4);
        power_up();

        // R2 fail during an active cycle
        ce_n_in = 1'b0;
        cyc(5);
        sup_below_5 = 1'b1; sup_below_10 = 1'b1;
        cyc(6);
        chk("R2", 0, 1'b0);
        ce_n_in = 1'b1;
        chk("R2", 0, 1'b1);
        cyc(6);
        ce_n_in = 1'b0;
        chk("R2", 0, 1'b1);
        ce_n_in = 1'b1;
        cyc(2);

        // low battery 1, no battery 2: second cycle refused
        bat1_low = 1'b1; bat2_present = 1'b0;
        power_up();
        chk("R8", 3, 1'b1);
        mem_cycle("R4", 1'b0);
        mem_cycle("R4", 1'b1);
        mem_cycle("R4", 1'b0);

        // R5 good, higher battery 2 in use
        power_down();
        bat2_present = 1'b1; bat2_higher = 1'b1; bat2_low = 1'b0;
        power_up();
        chk("R5", 3, 1'b0);
        chk("R8", 3, 1'b0);   // reloaded at this power-up
        mem_cycle("R5", 1'b0);
        mem_cycle("R5", 1'b0);

        // R5 absent battery 2 flagged low is ignored
        power_down();
        bat1_low = 1'b0; bat2_present = 1'b0; bat2_low = 1'b1; bat2_higher = 1'b1;
        power_up();
        chk("R5", 3, 1'b0);
        mem_cycle("R5", 1'b0);
        mem_cycle("R5", 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule